// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits between an I2C controller's byte engine and its open-drain pin drivers. In normal operation the SCL and SDA levels come straight from the engine. Software can take direct control of both lines by setting two mode bits together: a pin-override enable and a single-byte-mode bit. While both bits are set and the sequencer is idle, the lines follow two software level bits. On each line, 1 means released (pulled high) and 0 means driven low.

A hardware sequencer frees a bus on which a target device is holding SDA low. It takes a single start pulse and then drives the lines on its own. It first clocks nine SCL pulses with SDA released. It then waits one idle phase and forms a four-step STOP pattern. At the end it samples SDA and reports either success (`done`) or bus-busy (`err`). Every phase lasts `PHASE_CYC` clock cycles, which is 5 µs at the intended clock. The sequencer can also be launched by a bus-free watcher. The watcher fires when a pending transfer sees SDA held low for `WAIT_CYC` consecutive cycles, the 2 ms wait expressed in the same cycle units.

States, in order: `ST_IDLE` → `ST_CLK_HI` ⇄ `ST_CLK_LO` (nine rounds) → `ST_GAP` → `ST_STOP_A` → `ST_STOP_B` → `ST_STOP_C` → `ST_STOP_D` → `ST_REPORT` → `ST_HOLD`.
- `ST_HOLD` returns to `ST_IDLE` once the two mode bits are no longer both set.
- `ST_HOLD` re-enters `ST_CLK_HI` on a new launch.
- `ST_IDLE` enters `ST_CLK_HI` on a launch.
- Each timed state leaves when its phase timer ends.
- `ST_REPORT` lasts one cycle.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset the block is idle. `busy`, `done` and `err` are low, and `scl_out`/`sda_out` equal `eng_scl`/`eng_sda`.
- R2: While idle, `scl_out`/`sda_out` follow `ovr_scl_lvl`/`ovr_sda_lvl` when `ovr_pin_en` and `ovr_byte_mode` are both 1. Otherwise they follow the engine inputs.
- R3: `rec_start` sampled high while not busy raises `busy` from the next cycle. The first 18 phases then alternate SCL high and SCL low, starting high, with SDA at 1 throughout.
- R4: After the pulses, one idle phase holds (SCL,SDA)=(0,1). The STOP steps follow as (0,1), (0,0), (1,0), (1,1).
- R5: Every phase lasts exactly `PHASE_CYC` cycles. `ST_REPORT` therefore starts 23·`PHASE_CYC` cycles after the start edge, and `busy` stays high through it.
- R6: `sda_in` is sampled in the last cycle of the final STOP step. A 1 gives a one-cycle `done` pulse and a 0 gives a one-cycle `err` pulse, and the two pulses are never high together.
- R7: `rec_start` while `busy` is ignored and does not change the sequence or its timing.
- R8: After the report, both lines stay at 1 under override regardless of the software level bits, as long as both mode bits are set. From the cycle after the mode bits stop being both set, the lines follow the engine.
- R9: While `wait_free` is 1 and the block is not busy, `WAIT_CYC` consecutive cycles of `sda_in`=0 launch the sequence as if started. A cycle with `sda_in`=1 restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovr_pin_en | input | 1 | Pin-override enable mode bit |
| ovr_byte_mode | input | 1 | Single-byte mode bit, needed for override |
| ovr_scl_lvl | input | 1 | Software SCL level under override (1 = released) |
| ovr_sda_lvl | input | 1 | Software SDA level under override (1 = released) |
| eng_scl | input | 1 | SCL level from the byte engine |
| eng_sda | input | 1 | SDA level from the byte engine |
| sda_in | input | 1 | Sensed SDA line level |
| rec_start | input | 1 | Launch recovery |
| wait_free | input | 1 | A transfer is waiting for the bus to be free |
| scl_out | output | 1 | SCL level to the pad (1 = released) |
| sda_out | output | 1 | SDA level to the pad (1 = released) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: bus recovered |
| err | output | 1 | One-cycle pulse: SDA still low |

## Verification
A wrong state or a miscounted phase shows on `scl_out`/`sda_out` in the same cycle. The bench therefore compares the line pair against the expected phase on every cycle of the sequence. An error in the pulse counter shifts every later phase by at least `PHASE_CYC` cycles, and the report appears early or late. A wrong SDA sample shows as a swapped `done`/`err` in the one report cycle. A faulty hold exit shows one cycle after the mode bits drop, when the lines fail to return to the engine levels.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_GAP,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C,
        ST_STOP_D,
        ST_REPORT,
        ST_HOLD
    } unstick_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } pin_pair_t;

    // States whose length is set by the phase timer
    function automatic logic is_timed(unstick_state_e s);
        return (s != ST_IDLE) && (s != ST_REPORT) && (s != ST_HOLD);
    endfunction

endpackage

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
    parameter int unsigned PHASE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_end = run && (cnt_q == LAST);

endmodule

// File: rtl/unstick_bus_watch.sv
module unstick_bus_watch #(
    parameter int unsigned WAIT_CYC = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic sda_in,
    output logic trip
);
    localparam int unsigned WW = $clog2(WAIT_CYC + 1);
    localparam logic [WW-1:0] LAST = WW'(WAIT_CYC - 1);

    logic [WW-1:0] low_cnt_q;
    logic          low_seen;

    assign low_seen = armed && !sda_in;
    assign trip     = low_seen && (low_cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!low_seen || trip) begin
            low_cnt_q <= '0;
        end else begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/unstick_pin_mux.sv
module unstick_pin_mux
    import unstick_pkg::*;
(
    input  logic      seq_own,
    input  pin_pair_t seq_lvl,
    input  logic      sw_ovr,
    input  pin_pair_t sw_lvl,
    input  pin_pair_t eng_lvl,
    output pin_pair_t pins
);
    always_comb begin
        if (seq_own) begin
            pins = seq_lvl;
        end else if (sw_ovr) begin
            pins = sw_lvl;
        end else begin
            pins = eng_lvl;
        end
    end

endmodule

// File: rtl/unstick_seq.sv
module unstick_seq
    import unstick_pkg::*;
#(
    parameter int unsigned PULSE_COUNT = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic           phase_end,
    input  logic           sda_in,
    input  logic           ovr_mode,
    output unstick_state_e state,
    output logic           run_timer,
    output logic           seq_own,
    output pin_pair_t      seq_lvl,
    output logic           busy,
    output logic           done,
    output logic           err
);
    localparam int unsigned PW = $clog2(PULSE_COUNT + 1);
    localparam logic [PW-1:0] LAST_PULSE = PW'(PULSE_COUNT - 1);

    unstick_state_e st_q, st_d;
    logic [PW-1:0]  pulse_q;
    logic           ok_q;

    // State register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pulse_q <= '0;
            ok_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE || st_q == ST_HOLD) begin
                pulse_q <= '0;
            end else if (st_q == ST_CLK_LO && phase_end) begin
                pulse_q <= pulse_q + 1'b1;
            end
            if (st_q == ST_STOP_D && phase_end) begin
                ok_q <= sda_in;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (launch) st_d = ST_CLK_HI;
            ST_CLK_HI: if (phase_end) st_d = ST_CLK_LO;
            ST_CLK_LO: if (phase_end) st_d = (pulse_q == LAST_PULSE) ? ST_GAP : ST_CLK_HI;
            ST_GAP:    if (phase_end) st_d = ST_STOP_A;
            ST_STOP_A: if (phase_end) st_d = ST_STOP_B;
            ST_STOP_B: if (phase_end) st_d = ST_STOP_C;
            ST_STOP_C: if (phase_end) st_d = ST_STOP_D;
            ST_STOP_D: if (phase_end) st_d = ST_REPORT;
            ST_REPORT: st_d = ST_HOLD;
            ST_HOLD: begin
                if (launch)        st_d = ST_CLK_HI;
                else if (!ovr_mode) st_d = ST_IDLE;
            end
            default:   st_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        seq_lvl   = '{scl: 1'b1, sda: 1'b1};
        seq_own   = 1'b1;
        busy      = 1'b1;
        done      = 1'b0;
        err       = 1'b0;
        run_timer = is_timed(st_q);
        unique case (st_q)
            ST_IDLE: begin
                seq_own = 1'b0;
                busy    = 1'b0;
            end
            ST_CLK_HI: seq_lvl = '{scl: 1'b1, sda: 1'b1};
            ST_CLK_LO: seq_lvl = '{scl: 1'b0, sda: 1'b1};
            ST_GAP:    seq_lvl = '{scl: 1'b0, sda: 1'b1};
            ST_STOP_A: seq_lvl = '{scl: 1'b0, sda: 1'b1};
            ST_STOP_B: seq_lvl = '{scl: 1'b0, sda: 1'b0};
            ST_STOP_C: seq_lvl = '{scl: 1'b1, sda: 1'b0};
            ST_STOP_D: seq_lvl = '{scl: 1'b1, sda: 1'b1};
            ST_REPORT: begin
                done = ok_q;
                err  = !ok_q;
            end
            ST_HOLD:   busy = 1'b0;
            default: begin
                seq_own = 1'b0;
                busy    = 1'b0;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
    import unstick_pkg::*;
#(
    parameter int unsigned PHASE_CYC   = 1000,
    parameter int unsigned PULSE_COUNT = 9,
    parameter int unsigned WAIT_CYC    = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_pin_en,
    input  logic ovr_byte_mode,
    input  logic ovr_scl_lvl,
    input  logic ovr_sda_lvl,
    input  logic eng_scl,
    input  logic eng_sda,
    input  logic sda_in,
    input  logic rec_start,
    input  logic wait_free,
    output logic scl_out,
    output logic sda_out,
    output logic busy,
    output logic done,
    output logic err
);
    unstick_state_e seq_st;
    logic           run_timer;
    logic           phase_end;
    logic           seq_own;
    logic           trip;
    logic           launch;
    logic           ovr_mode;
    pin_pair_t      seq_lvl;
    pin_pair_t      sw_lvl;
    pin_pair_t      eng_lvl;
    pin_pair_t      pins;

    assign ovr_mode = ovr_pin_en && ovr_byte_mode;
    assign launch   = rec_start || trip;
    assign sw_lvl   = '{scl: ovr_scl_lvl, sda: ovr_sda_lvl};
    assign eng_lvl  = '{scl: eng_scl, sda: eng_sda};

    unstick_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_timer),
        .phase_end (phase_end)
    );

    unstick_bus_watch #(.WAIT_CYC(WAIT_CYC)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (wait_free && !busy),
        .sda_in (sda_in),
        .trip   (trip)
    );

    unstick_seq #(.PULSE_COUNT(PULSE_COUNT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .phase_end (phase_end),
        .sda_in    (sda_in),
        .ovr_mode  (ovr_mode),
        .state     (seq_st),
        .run_timer (run_timer),
        .seq_own   (seq_own),
        .seq_lvl   (seq_lvl),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    unstick_pin_mux u_mux (
        .seq_own (seq_own),
        .seq_lvl (seq_lvl),
        .sw_ovr  (ovr_mode),
        .sw_lvl  (sw_lvl),
        .eng_lvl (eng_lvl),
        .pins    (pins)
    );

    assign scl_out = pins.scl;
    assign sda_out = pins.sda;

endmodule

// File: rtl/unstick_chk.sv
module unstick_chk
    import unstick_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           rec_start,
    input logic           ovr_pin_en,
    input logic           ovr_byte_mode,
    input logic           ovr_scl_lvl,
    input logic           ovr_sda_lvl,
    input logic           eng_scl,
    input logic           eng_sda,
    input logic           scl_out,
    input logic           sda_out,
    input logic           busy,
    input logic           done,
    input logic           err,
    input unstick_state_e seq_st
);
    a_r1_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_IDLE && !(ovr_pin_en && ovr_byte_mode))
            |-> (scl_out == eng_scl && sda_out == eng_sda));

    a_r2_sw_override: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_IDLE && ovr_pin_en && ovr_byte_mode)
            |-> (scl_out == ovr_scl_lvl && sda_out == ovr_sda_lvl));

    a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_start && !busy) |=> busy);

    a_r3_pulse_sda_released: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_CLK_HI || seq_st == ST_CLK_LO) |-> sda_out);

    a_r4_stop_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_STOP_B) |-> (!scl_out && !sda_out));

    a_r5_busy_ends_at_report: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || err));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));

    a_r7_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(done || err)) |=> busy);

    a_r8_released_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (scl_out && sda_out));

endmodule

bind i2c_bus_unstick unstick_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rec_start     (rec_start),
    .ovr_pin_en    (ovr_pin_en),
    .ovr_byte_mode (ovr_byte_mode),
    .ovr_scl_lvl   (ovr_scl_lvl),
    .ovr_sda_lvl   (ovr_sda_lvl),
    .eng_scl       (eng_scl),
    .eng_sda       (eng_sda),
    .scl_out       (scl_out),
    .sda_out       (sda_out),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .seq_st        (seq_st)
);

// File: tb/i2c_bus_unstick_tb.sv
`timescale 1ns/1ps
module i2c_bus_unstick_tb;
    localparam int PH   = 4;
    localparam int WAIT = 20;
    localparam int NPH  = 23;

    // Expected {scl, sda} per phase: 9 pulses, gap, four STOP steps
    localparam logic [1:0] TAB [NPH] = '{
        2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11,
        2'b01, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01,
        2'b01, 2'b01, 2'b00, 2'b10, 2'b11
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovr_pin_en = 1'b0, ovr_byte_mode = 1'b0;
    logic ovr_scl_lvl = 1'b0, ovr_sda_lvl = 1'b0;
    logic eng_scl = 1'b0, eng_sda = 1'b1;
    logic rec_start = 1'b0, wait_free = 1'b0, hold_low = 1'b0;
    logic sda_in, scl_out, sda_out, busy, done, err;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_in = sda_out & ~hold_low;

    i2c_bus_unstick #(.PHASE_CYC(PH), .PULSE_COUNT(9), .WAIT_CYC(WAIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ovr_pin_en(ovr_pin_en), .ovr_byte_mode(ovr_byte_mode),
        .ovr_scl_lvl(ovr_scl_lvl), .ovr_sda_lvl(ovr_sda_lvl), .eng_scl(eng_scl),
        .eng_sda(eng_sda), .sda_in(sda_in), .rec_start(rec_start), .wait_free(wait_free),
        .scl_out(scl_out), .sda_out(sda_out), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Called in the cycle after the launch edge; walks the phase table
    task automatic walk(input logic exp_ok);
        for (int k = 0; k < NPH * PH; k++) begin
            chk("R5 busy during sequence", {7'd0, busy}, 8'd1);
            chk("R3 R4 line pair per phase", {6'd0, scl_out, sda_out}, {6'd0, TAB[k / PH]});
            rec_start = (k == 10); // R7: extra start mid-sequence must be ignored
            @(negedge clk);
        end
        rec_start = 1'b0;
        chk("R6 report cycle busy/done/err", {5'd0, busy, done, err},
            {5'd0, 1'b1, exp_ok, ~exp_ok});
        @(negedge clk);
        chk("R6 pulse one cycle", {5'd0, busy, done, err}, 8'd0);
    endtask

    task automatic launch_and_walk(input logic exp_ok);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        walk(exp_ok);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {3'd0, busy, done, err, scl_out, sda_out}, 8'b0000_0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {3'd0, busy, done, err, scl_out, sda_out}, 8'b0000_0001);

        // R2: override mux
        ovr_pin_en = 1'b1; ovr_scl_lvl = 1'b1; ovr_sda_lvl = 1'b0;
        @(negedge clk);
        chk("R2 one mode bit only -> engine", {6'd0, scl_out, sda_out}, 8'b01);
        ovr_byte_mode = 1'b1;
        @(negedge clk);
        chk("R2 override 1/0", {6'd0, scl_out, sda_out}, 8'b10);
        ovr_scl_lvl = 1'b0; ovr_sda_lvl = 1'b1;
        @(negedge clk);
        chk("R2 override 0/1", {6'd0, scl_out, sda_out}, 8'b01);
        ovr_scl_lvl = 1'b0; ovr_sda_lvl = 1'b0;
        @(negedge clk);
        chk("R2 override 0/0", {6'd0, scl_out, sda_out}, 8'b00);

        // R3 R4 R5 R6 R7: clean bus, mode set
        launch_and_walk(1'b1);

        // R8: hold released while mode set
        chk("R8 held released", {5'd0, busy, scl_out, sda_out}, 8'b011);
        repeat (3) @(negedge clk);
        chk("R8 still released", {5'd0, busy, scl_out, sda_out}, 8'b011);
        ovr_byte_mode = 1'b0;
        chk("R8 release until edge", {6'd0, scl_out, sda_out}, 8'b11);
        @(negedge clk);
        chk("R8 back to engine", {6'd0, scl_out, sda_out}, 8'b01);

        // R6: stuck bus, mode clear
        ovr_pin_en = 1'b0;
        hold_low = 1'b1;
        launch_and_walk(1'b0);
        @(negedge clk);
        chk("R8 mode clear -> engine after hold", {5'd0, busy, scl_out, sda_out}, 8'b001);

        // R9: watcher does not trip while SDA high
        hold_low = 1'b0; wait_free = 1'b1;
        repeat (WAIT + 10) @(negedge clk);
        chk("R9 no trip with SDA high", {7'd0, busy}, 8'd0);

        // R9: low run interrupted restarts count
        hold_low = 1'b1;
        repeat (10) @(negedge clk);
        hold_low = 1'b0;
        @(negedge clk);
        hold_low = 1'b1;
        repeat (WAIT - 1) @(negedge clk);
        chk("R9 not yet tripped", {7'd0, busy}, 8'd0);
        @(negedge clk);
        wait_free = 1'b0;
        walk(1'b0);

        // R7: start while idle after all this still accepted cleanly
        hold_low = 1'b0;
        @(negedge clk);
        launch_and_walk(1'b1);

        finish_run();
    end

endmodule